// File: doc/BRIEF.md
# Processor I/O Trap and Bus Handoff Controller

This block watches the I/O cycles of an 8-bit processor bus that has separate I/O request, read and write strobes. It reacts when the processor issues an I/O request to any of sixteen ports, namely the ports whose low address byte has its upper nibble equal to 1000 (0x80 through 0x8F). A trap latch then sets, drops the wait line at once, and raises a status flag. The processor stays frozen in wait states while a service agent behind a simple command interface decides what to do with the request.

A sequencer, clocked from the local clock, sees only synchronized copies of the bus strobes. It records a 12-bit command key made from the address bits that the window decode does not fix. It also records the direction of the cycle and, for a write, the data byte. It offers all of this to the service side and waits for the answer.

For a read it drives the answer byte, requests the bus, and only then clears the trap. The processor takes the byte and stops at the bus request. Once the bus is granted, the data drivers turn off. A write that needs memory access follows the same path without driving data. Either kind can open a DMA window that lasts until the service side signals completion. A write that needs no memory access only clears the trap. It then waits for the I/O request to end, and no bus request is made.

Top module: `iotrap_ctrl`

## Requirements
- R1: During and right after reset, wait_n and busreq_n are 1, data_oe, trap_status, trap_valid and dma_window are 0.
- R2: With iorq_n low and addr[7:4] = 4'b1000 while the block is idle, wait_n goes low and trap_status goes high without waiting for a clock edge.
- R3: An address outside the window (addr[7:4] not 4'b1000), or a read or write strobe without iorq_n low, sets no trap: wait_n stays 1 and trap_valid stays 0.
- R4: After a trap, trap_valid rises with cmd_addr = {addr[15:8], addr[3:0]}, with cmd_is_in = 1 when rd_n was low, and with cmd_wdata holding data_in when wr_n was low (0 for a read). trap_valid stays high until resp_valid, and trap_status stays 1 throughout.
- R5: For a read, once resp_valid is accepted, data_out carries resp_data with data_oe = 1 and busreq_n = 0 before wait_n returns to 1. data_oe stays 1 until busack_n has gone low, and then goes to 0.
- R6: When resp_dma = 1, dma_window rises only after busack_n is low, stays up with busreq_n low, and falls after a dma_done pulse. With resp_dma = 0 on a read, dma_window never rises.
- R7: On the bus-held path, busreq_n returns to 1 only when iorq_n is high, the trap release has already ended, and trap_status is 0.
- R8: A write answered with resp_dma = 0 releases wait_n without ever pulling busreq_n low. After iorq_n goes high the block is idle and can trap again.
- R9: While the sequencer is busy with a trap, a new window hit sets no trap (wait_n stays 1, trap_status stays 0).
- R10: While trap_valid is waiting for an answer, wait_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| data_in | input | 8 | Processor data bus as seen by the block |
| data_out | output | 8 | Byte driven to the processor for a read |
| data_oe | output | 1 | Enable for the data_out drivers (0 = bus released) |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| busack_n | input | 1 | Bus grant from the processor, active low |
| wait_n | output | 1 | Wait request to the processor, active low |
| busreq_n | output | 1 | Bus request to the processor, active low |
| trap_status | output | 1 | Trap latch state |
| trap_valid | output | 1 | A captured command is waiting for an answer |
| cmd_addr | output | 12 | Command key {A15..A8, A3..A0} |
| cmd_is_in | output | 1 | 1 for a read cycle, 0 for a write cycle |
| cmd_wdata | output | 8 | Byte written by the processor |
| resp_valid | input | 1 | Service side answers the command |
| resp_data | input | 8 | Byte returned for a read |
| resp_dma | input | 1 | Answer asks for a bus-held DMA window |
| dma_window | output | 1 | Bus is held and free for DMA |
| dma_done | input | 1 | Ends the DMA window |

## Verification
A table of bus cycles covers all four service paths: reads with and without DMA, and writes with and without DMA. The table places the port numbers at both ends of the window and uses varied upper address bytes, so a wrong command key, direction or data byte shows up. Addresses just outside the window, and strobes given without the I/O request, separate a correct nibble decode from a loose one. A window hit during a DMA window separates a trap that re-arms only in idle from one that re-arms early. Checks on the order of the bus request, data drive, wait release and bus grant separate a correct handoff from one that lets the processor run too early or lets go of the data too soon.

// File: rtl/iotrap_pkg.sv
package iotrap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // armed, waiting for a latched trap
    ST_SERVE,  // command offered to the service side
    ST_REQ,    // bus request raised ahead of the release
    ST_HOLD,   // trap released, waiting for the bus grant
    ST_DMA,    // bus held, DMA window open
    ST_UNCLR,  // waiting for the I/O request to end
    ST_REL,    // release dropped, bus request still held
    ST_FAST    // write without DMA: release only
  } seq_state_e;

  // Window decode on the upper nibble of the low address byte
  function automatic logic port_hit(input logic [15:0] a, input logic [3:0] nib);
    return a[7:4] == nib;
  endfunction

  // Address bits left free by the window decode form the command key
  function automatic logic [11:0] cmd_key(input logic [15:0] a);
    return {a[15:8], a[3:0]};
  endfunction

endpackage

// File: rtl/iotrap_sync.sv
module iotrap_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[0] <= RST_VAL;
          else        pipe[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[g] <= RST_VAL;
          else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/iotrap_latch.sv
module iotrap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr,
  output logic q
);
  // Set takes effect at once; clear waits for the clock
  always_ff @(posedge clk or posedge set_req or negedge rst_n)
    if (!rst_n)       q <= 1'b0;
    else if (set_req) q <= 1'b1;
    else if (clr)     q <= 1'b0;
endmodule

// File: rtl/iotrap_seq.sv
module iotrap_seq
  import iotrap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_s,
  input  logic              iorq_s,
  input  logic              rd_s,
  input  logic              wr_s,
  input  logic              busack_s,
  input  logic [15:0]       addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              resp_valid,
  input  logic [DATA_W-1:0] resp_data,
  input  logic              resp_dma,
  input  logic              dma_done,
  output logic              trap_valid,
  output logic [CMD_W-1:0]  cmd_addr,
  output logic              cmd_is_in,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              busreq_n,
  output logic              trap_clr,
  output logic              dma_window,
  output logic              seq_idle
);
  seq_state_e state, state_nx;
  logic       need_dma;
  logic       io_ended;

  assign io_ended = iorq_s && !trap_s;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (trap_s) state_nx = ST_SERVE;
      ST_SERVE: if (resp_valid) state_nx = (cmd_is_in || resp_dma) ? ST_REQ : ST_FAST;
      ST_REQ:   state_nx = ST_HOLD;
      ST_HOLD:  if (!busack_s) state_nx = need_dma ? ST_DMA : ST_UNCLR;
      ST_DMA:   if (dma_done) state_nx = ST_UNCLR;
      ST_UNCLR: if (io_ended) state_nx = ST_REL;
      ST_REL:   state_nx = ST_IDLE;
      ST_FAST:  if (io_ended) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= ST_IDLE;
      need_dma  <= 1'b0;
      cmd_addr  <= '0;
      cmd_is_in <= 1'b0;
      cmd_wdata <= '0;
      data_out  <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && trap_s) begin
        cmd_addr  <= cmd_key(addr);
        cmd_is_in <= !rd_s;
        cmd_wdata <= !wr_s ? data_in : '0;
      end
      if (state == ST_SERVE && resp_valid) begin
        need_dma <= resp_dma;
        data_out <= resp_data;
      end
    end

  assign seq_idle   = (state == ST_IDLE);
  assign trap_valid = (state == ST_SERVE);
  assign dma_window = (state == ST_DMA);
  assign data_oe    = cmd_is_in && (state == ST_REQ || state == ST_HOLD);
  assign trap_clr   = (state == ST_HOLD) || (state == ST_DMA) ||
                      (state == ST_UNCLR) || (state == ST_FAST);
  assign busreq_n   = !((state == ST_REQ) || (state == ST_HOLD) || (state == ST_DMA) ||
                        (state == ST_UNCLR) || (state == ST_REL));
endmodule

// File: rtl/iotrap_ctrl.sv
module iotrap_ctrl
  import iotrap_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] WINDOW_NIB  = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              busack_n,
  output logic              wait_n,
  output logic              busreq_n,
  output logic              trap_status,
  output logic              trap_valid,
  output logic [11:0]       cmd_addr,
  output logic              cmd_is_in,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              resp_valid,
  input  logic [DATA_W-1:0] resp_data,
  input  logic              resp_dma,
  output logic              dma_window,
  input  logic              dma_done
);
  localparam int CMD_W  = 12;
  localparam int STRB_W = 4;

  logic              trap_q, trap_set, trap_clr, seq_idle, trap_s;
  logic [STRB_W-1:0] strb_s;

  // Trap may set only while idle and not releasing
  assign trap_set = seq_idle && !trap_clr && !iorq_n && port_hit(addr, WINDOW_NIB);

  iotrap_latch latch_i (
    .clk(clk), .rst_n(rst_n), .set_req(trap_set), .clr(trap_clr), .q(trap_q)
  );

  iotrap_sync #(.W(STRB_W), .STAGES(SYNC_STAGES), .RST_VAL({STRB_W{1'b1}})) strb_sync_i (
    .clk(clk), .rst_n(rst_n), .d({iorq_n, rd_n, wr_n, busack_n}), .q(strb_s)
  );

  iotrap_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) trap_sync_i (
    .clk(clk), .rst_n(rst_n), .d(trap_q), .q(trap_s)
  );

  iotrap_seq #(.DATA_W(DATA_W), .CMD_W(CMD_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .trap_s(trap_s), .iorq_s(strb_s[3]), .rd_s(strb_s[2]), .wr_s(strb_s[1]),
    .busack_s(strb_s[0]),
    .addr(addr), .data_in(data_in),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_dma(resp_dma),
    .dma_done(dma_done),
    .trap_valid(trap_valid), .cmd_addr(cmd_addr), .cmd_is_in(cmd_is_in),
    .cmd_wdata(cmd_wdata), .data_out(data_out), .data_oe(data_oe),
    .busreq_n(busreq_n), .trap_clr(trap_clr), .dma_window(dma_window),
    .seq_idle(seq_idle)
  );

  assign wait_n      = !trap_q;
  assign trap_status = trap_q;
endmodule

// File: rtl/iotrap_chk.sv
module iotrap_chk (
  input logic clk,
  input logic rst_n,
  input logic wait_n,
  input logic busreq_n,
  input logic data_oe,
  input logic busack_n,
  input logic iorq_n,
  input logic dma_window,
  input logic trap_valid,
  input logic trap_status,
  input logic seq_idle,
  input logic trap_clr
);
  // R4
  valid_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> trap_status);

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_oe && $past(data_oe)) |-> !busack_n);

  // R6
  dma_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_window |-> (!busreq_n && !busack_n));

  // R7
  busreq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busreq_n && !$past(busreq_n)) |-> (iorq_n && !trap_clr && !trap_status));

  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_idle && !trap_status) |=> !trap_status);

  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !wait_n) |=> !wait_n);
endmodule

bind iotrap_ctrl iotrap_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wait_n(wait_n), .busreq_n(busreq_n),
  .data_oe(data_oe), .busack_n(busack_n), .iorq_n(iorq_n),
  .dma_window(dma_window), .trap_valid(trap_valid), .trap_status(trap_status),
  .seq_idle(seq_idle), .trap_clr(trap_clr)
);

// File: tb/iotrap_ctrl_tb.sv
module iotrap_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;
  localparam int NVEC       = 6;

  typedef struct packed {
    logic [15:0] a;
    logic        is_in;
    logic [7:0]  d;
    logic        dma;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{a:16'h3480, is_in:1'b1, d:8'h5A, dma:1'b0},
    '{a:16'hC78F, is_in:1'b0, d:8'h3C, dma:1'b1},
    '{a:16'h0185, is_in:1'b1, d:8'hE1, dma:1'b1},
    '{a:16'hFF8A, is_in:1'b0, d:8'h96, dma:1'b0},
    '{a:16'h5A83, is_in:1'b0, d:8'h00, dma:1'b1},
    '{a:16'h008C, is_in:1'b1, d:8'hFF, dma:1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data_in = '0, resp_data = '0;
  logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, busack_n = 1'b1;
  logic        resp_valid = 1'b0, resp_dma = 1'b0, dma_done = 1'b0;
  logic [7:0]  data_out, cmd_wdata;
  logic [11:0] cmd_addr;
  logic        data_oe, wait_n, busreq_n, trap_status, trap_valid, cmd_is_in, dma_window;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iotrap_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .busack_n(busack_n),
    .wait_n(wait_n), .busreq_n(busreq_n), .trap_status(trap_status),
    .trap_valid(trap_valid), .cmd_addr(cmd_addr), .cmd_is_in(cmd_is_in),
    .cmd_wdata(cmd_wdata), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_dma(resp_dma), .dma_window(dma_window), .dma_done(dma_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT && !done) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
        report();
      end
    end
  end

  task automatic check_quiet(input string req, input logic [15:0] a, input logic iq);
    logic bad;
    bad = 1'b0;
    @(negedge clk);
    addr = a; iorq_n = iq; rd_n = 1'b0; wr_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bad |= !wait_n || trap_valid;
    end
    chk(!bad, req, {15'd0, wait_n, 15'd0, trap_valid}, 32'h10000);
    iorq_n = 1'b1; rd_n = 1'b1;
    tick(4);
  endtask

  task automatic run_vec(input vec_t v);
    logic saw_req, saw_dma;
    int   k;
    saw_req = 1'b0; saw_dma = 1'b0;
    @(negedge clk);
    addr = v.a; data_in = v.is_in ? 8'h00 : v.d;
    iorq_n = 1'b0; rd_n = !v.is_in; wr_n = v.is_in;
    #1;
    // R2: immediate wait and status
    chk(!wait_n && trap_status, "R2", {wait_n, trap_status}, 2'b01);
    @(negedge clk);
    k = 0;
    while (!trap_valid && k < 20) begin saw_req |= !busreq_n; @(negedge clk); k++; end
    // R4: command fields
    chk(trap_valid, "R4 valid", trap_valid, 1);
    chk(cmd_addr == {v.a[15:8], v.a[3:0]}, "R4 cmd_addr", cmd_addr, {v.a[15:8], v.a[3:0]});
    chk(cmd_is_in == v.is_in, "R4 dir", cmd_is_in, v.is_in);
    chk(cmd_wdata == (v.is_in ? 8'h00 : v.d), "R4 wdata", cmd_wdata, v.is_in ? 8'h00 : v.d);
    tick(3);
    // R10: wait held while unanswered
    chk(!wait_n && trap_valid && trap_status, "R10", {wait_n, trap_valid}, 2'b01);
    resp_valid = 1'b1; resp_data = v.d; resp_dma = v.dma;
    @(negedge clk);
    resp_valid = 1'b0;
    k = 0;
    while (!wait_n && k < 20) begin saw_req |= !busreq_n; @(negedge clk); k++; end
    chk(wait_n, "R5/R8 wait release", wait_n, 1);
    if (v.is_in || v.dma) begin
      // R5: bus request precedes release; read data driven
      chk(!busreq_n, "R5 busreq before release", busreq_n, 0);
      if (v.is_in) chk(data_oe && data_out == v.d, "R5 data drive", {data_oe, data_out}, {1'b1, v.d});
    end else begin
      // R8: no bus request on plain write
      chk(!saw_req && busreq_n, "R8 no busreq", {saw_req, busreq_n}, 2'b01);
    end
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    if (v.is_in || v.dma) begin
      tick(4);
      if (v.is_in) chk(data_oe, "R5 hold drive until grant", data_oe, 1);
      chk(!dma_window, "R6 no window before grant", dma_window, 0);
      busack_n = 1'b0;
      k = 0;
      while (data_oe && k < 20) begin @(negedge clk); k++; end
      chk(!data_oe, "R5 drive off after grant", data_oe, 0);
      if (v.dma) begin
        k = 0;
        while (!dma_window && k < 20) begin @(negedge clk); k++; end
        chk(dma_window && !busreq_n, "R6 window open", {dma_window, busreq_n}, 2'b10);
        // R9: new hit ignored while busy
        addr = 16'h248A; iorq_n = 1'b0; wr_n = 1'b0;
        tick(3);
        chk(wait_n && !trap_status, "R9 no retrigger", {wait_n, trap_status}, 2'b10);
        iorq_n = 1'b1; wr_n = 1'b1;
        tick(4);
        chk(dma_window, "R6 window held", dma_window, 1);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
      end
      k = 0;
      while (!busreq_n && k < 20) begin saw_dma |= dma_window; @(negedge clk); k++; end
      chk(busreq_n && !trap_status && wait_n, "R7 bus released", {busreq_n, trap_status}, 2'b10);
      if (!v.dma) chk(!saw_dma && !dma_window, "R6 no window without dma", saw_dma, 0);
      busack_n = 1'b1;
    end else begin
      for (int i = 0; i < 6; i++) begin @(negedge clk); saw_req |= !busreq_n; end
      chk(!saw_req && !trap_status && wait_n, "R8 idle after write", {saw_req, trap_status}, 0);
    end
    tick(4);
  endtask

  initial begin
    tick(1);
    // R1: outputs during reset
    chk(wait_n && busreq_n && !data_oe && !trap_status && !trap_valid && !dma_window,
        "R1 in reset", {wait_n, busreq_n, data_oe, trap_status, trap_valid, dma_window}, 6'b110000);
    tick(2);
    rst_n = 1'b1;
    tick(2);
    chk(wait_n && busreq_n && !data_oe && !trap_status && !trap_valid && !dma_window,
        "R1 after reset", {wait_n, busreq_n, data_oe, trap_status, trap_valid, dma_window}, 6'b110000);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R3: near-miss windows and strobe without request
    check_quiet("R3 addr 0x90", 16'h1290, 1'b0);
    check_quiet("R3 addr 0x7F", 16'h127F, 1'b0);
    check_quiet("R3 no iorq", 16'h1285, 1'b1);

    // R8: back-to-back trap works after plain write
    run_vec(VECS[3]);
    run_vec(VECS[0]);

    done = 1'b1;
    report();
  end
endmodule